// File: doc/BRIEF.md
# ECC Error Logger

This block sits next to a memory controller's ECC check logic and records what that logic reports. The check logic gives it three things: a strobe for a correctable (single-bit) error, a strobe for an uncorrectable (multi-bit) error, and the failing physical address with its row index. The block keeps an error pointer that holds the failing 4 KB page and two class flags, a status word that holds per-class flags and the row of the first event of each class, and a command byte that decides which classes raise a system-error pulse. No syndrome is stored.

Software reaches all three registers through a byte-wide configuration port. Reads are combinational. Writes take effect at the clock edge. Flags are cleared by writing one to them. After the first event the pointer keeps its page until software has cleared both of its flags. Each row field keeps its value until the flag of its class is cleared. This way the first failure is not overwritten by later ones.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register byte reads zero and `serr_o` is low.
- R2: Bytes 0x80 (least significant) to 0x83 read the pointer word. Bits 31:12 are the page of the captured address, bit 1 is the multi-bit flag, bit 0 is the single-bit flag, and bits 11:2 read zero. Address bits 11:0 are never stored.
- R3: While either pointer flag is set, no event changes the stored page. An event that arrives while both pointer flags are clear loads the page of `err_addr_i`.
- R4: Pointer bit 0 sets on a single-bit strobe and bit 1 sets on a multi-bit strobe. Writing a one to bit 0 or bit 1 at byte 0x80 clears that flag, and writing zeros there has no effect. Writes to bytes 0x81 to 0x83 are ignored.
- R5: When both strobes assert in the same cycle, both pointer flags and both status flags set and one page is captured.
- R6: Byte 0x90 is the command byte. Bit 0 enables the system error on single-bit events and bit 1 enables it on multi-bit events. Both bits are read/write and bits 7:2 read zero.
- R7: Byte 0x91 is the status byte: bit 0 is the single-bit flag, bits 3:1 hold the single-bit row, bit 4 is the multi-bit flag and bits 7:5 hold the multi-bit row. A row field loads `err_row_i` only on an event of its class while that class flag is clear. Bits 0 and 4 clear when a one is written to them. Byte 0x92 (upper status byte) reads zero.
- R8: `serr_o` goes high for exactly the one cycle after the clock edge where a status flag goes from clear to set, provided that class is enabled in the command byte as it stood before that edge.
- R9: If an event and a write-one clear of the same flag fall in the same cycle, the flag stays set.
- R10: Addresses other than 0x80 to 0x83, 0x90, 0x91 and 0x92 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_evt_i | input | 1 | Single-bit (corrected) error strobe, one cycle per event |
| mbe_evt_i | input | 1 | Multi-bit (uncorrectable) error strobe, one cycle per event |
| err_addr_i | input | 32 | Physical address of the failing access |
| err_row_i | input | 3 | Row index of the failing access |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write byte |
| cfg_rdata_o | output | 8 | Configuration read byte for `cfg_addr_i` (combinational) |
| serr_o | output | 1 | System-error pulse |

## Verification
The assertions take the error strobes as plain one-cycle level inputs. They also assume that the address and row are valid in any cycle where a strobe is high, and that a write is a single-cycle strobe with a stable address. The stimulus drives every input shortly after the falling edge and returns the strobes to zero after each cycle, so each event and write lasts exactly one cycle. The random phase keeps events sparse, so that flags are seen both locked and unlocked. It also draws write addresses mostly from the defined bytes, so that clears and clear-versus-event races come up often.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_PAGE_SHIFT = 12;
  localparam int unsigned DEF_ROW_W      = 3;
  localparam int unsigned DEF_CFG_AW     = 8;
  localparam int unsigned CMD_BITS       = 2;
  localparam int unsigned STS_BYTES      = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STS  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ecc_ptr_reg.sv
module ecc_ptr_reg #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sbe_evt_i,
  input  logic                         mbe_evt_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         clr_sbe_i,
  input  logic                         clr_mbe_i,
  output logic [ADDR_W-PAGE_SHIFT-1:0] page_o,
  output logic                         sbe_flag_o,
  output logic                         mbe_flag_o,
  output logic                         capture_o
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  logic [PAGE_W-1:0] page_q;
  logic              sbe_q, mbe_q;
  logic              locked;
  logic              unused_low_addr;

  assign unused_low_addr = ^addr_i[PAGE_SHIFT-1:0];
  assign locked    = sbe_q | mbe_q;
  assign capture_o = (sbe_evt_i | mbe_evt_i) & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
    end else begin
      if (capture_o) page_q <= page_of(addr_i);
      sbe_q <= (sbe_q & ~clr_sbe_i) | sbe_evt_i;
      mbe_q <= (mbe_q & ~clr_mbe_i) | mbe_evt_i;
    end
  end

  assign page_o     = page_q;
  assign sbe_flag_o = sbe_q;
  assign mbe_flag_o = mbe_q;

  AST_PTR_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_q || mbe_q) |=> $stable(page_q)); // R3
  AST_PTR_SBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_evt_i |=> sbe_q); // R4
  AST_PTR_BOTH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_evt_i && mbe_evt_i) |=> (sbe_q && mbe_q)); // R5
  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mbe_i && !mbe_evt_i) |=> !mbe_q); // R4
  AST_PTR_CLR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sbe_i && sbe_evt_i) |=> sbe_q); // R9
endmodule

// File: rtl/ecc_sts_reg.sv
module ecc_sts_reg #(
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_evt_i,
  input  logic             mbe_evt_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             clr_sef_i,
  input  logic             clr_mef_i,
  output logic             sef_o,
  output logic             mef_o,
  output logic [ROW_W-1:0] srow_o,
  output logic [ROW_W-1:0] mrow_o,
  output logic             new_sbe_o,
  output logic             new_mbe_o
);
  logic             sef_q, mef_q;
  logic [ROW_W-1:0] srow_q, mrow_q;

  assign new_sbe_o = sbe_evt_i & ~sef_q;
  assign new_mbe_o = mbe_evt_i & ~mef_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sef_q  <= 1'b0;
      mef_q  <= 1'b0;
      srow_q <= '0;
      mrow_q <= '0;
    end else begin
      if (new_sbe_o) srow_q <= row_i;
      if (new_mbe_o) mrow_q <= row_i;
      sef_q <= (sef_q & ~clr_sef_i) | sbe_evt_i;
      mef_q <= (mef_q & ~clr_mef_i) | mbe_evt_i;
    end
  end

  assign sef_o  = sef_q;
  assign mef_o  = mef_q;
  assign srow_o = srow_q;
  assign mrow_o = mrow_q;

  AST_STS_SROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sef_q |=> $stable(srow_q)); // R7
  AST_STS_MROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mef_q |=> $stable(mrow_q)); // R7
  AST_STS_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mbe_evt_i && !mef_q) |=> (mrow_q == $past(row_i))); // R7
  AST_STS_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mef_i && mbe_evt_i) |=> mef_q); // R9
endmodule

// File: rtl/ecc_serr_gen.sv
module ecc_serr_gen #(
  parameter int unsigned CMD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             new_sbe_i,
  input  logic             new_mbe_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             serr_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             serr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      serr_q <= 1'b0;
    end else begin
      if (cmd_we_i) cmd_q <= cmd_wdata_i;
      serr_q <= (new_sbe_i & cmd_q[0]) | (new_mbe_i & cmd_q[1]);
    end
  end

  assign cmd_o  = cmd_q;
  assign serr_o = serr_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we_i |=> $stable(cmd_q)); // R6
  AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_q |-> ($past(new_sbe_i && cmd_q[0]) || $past(new_mbe_i && cmd_q[1]))); // R8
endmodule

// File: rtl/ecc_cfg_port.sv
module ecc_cfg_port
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned PTR_BASE = 'h80,
  parameter int unsigned CMD_OFS  = 'h90,
  parameter int unsigned STS_OFS  = 'h91
) (
  input  logic                 cfg_wr_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [7:0]           cfg_wdata_i,
  input  logic [ADDR_W-1:0]    ptr_word_i,
  input  logic [CMD_BITS-1:0]  cmd_i,
  input  logic [8*STS_BYTES-1:0] sts_word_i,
  output logic                 clr_psbe_o,
  output logic                 clr_pmbe_o,
  output logic                 clr_sef_o,
  output logic                 clr_mef_o,
  output logic                 cmd_we_o,
  output logic [CMD_BITS-1:0]  cmd_wdata_o,
  output logic [7:0]           rdata_o
);
  localparam int unsigned PTR_BYTES = ADDR_W / 8;
  localparam int unsigned MEF_BIT   = ROW_W + 1;

  reg_sel_e wsel;
  logic     unused_wbits;

  assign unused_wbits = ^{cfg_wdata_i[7:MEF_BIT+1], cfg_wdata_i[MEF_BIT-1:2]};

  always_comb begin
    wsel = SEL_NONE;
    if (cfg_addr_i == CFG_AW'(PTR_BASE)) wsel = SEL_PTR;
    else if (cfg_addr_i == CFG_AW'(CMD_OFS)) wsel = SEL_CMD;
    else if (cfg_addr_i == CFG_AW'(STS_OFS)) wsel = SEL_STS;
  end

  assign clr_psbe_o  = cfg_wr_i && (wsel == SEL_PTR) && cfg_wdata_i[0];
  assign clr_pmbe_o  = cfg_wr_i && (wsel == SEL_PTR) && cfg_wdata_i[1];
  assign clr_sef_o   = cfg_wr_i && (wsel == SEL_STS) && cfg_wdata_i[0];
  assign clr_mef_o   = cfg_wr_i && (wsel == SEL_STS) && cfg_wdata_i[MEF_BIT];
  assign cmd_we_o    = cfg_wr_i && (wsel == SEL_CMD);
  assign cmd_wdata_o = cfg_wdata_i[CMD_BITS-1:0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < PTR_BYTES; i++) begin
      if (cfg_addr_i == CFG_AW'(PTR_BASE + i)) rdata_o = ptr_word_i[i*8 +: 8];
    end
    if (cfg_addr_i == CFG_AW'(CMD_OFS)) rdata_o = {{(8-CMD_BITS){1'b0}}, cmd_i};
    for (int j = 0; j < STS_BYTES; j++) begin
      if (cfg_addr_i == CFG_AW'(STS_OFS + j)) rdata_o = sts_word_i[j*8 +: 8];
    end
  end

  always_comb begin
    assert ($onehot0({clr_psbe_o | clr_pmbe_o, clr_sef_o | clr_mef_o, cmd_we_o}))
      else $error("AST_CFG_ONE_TARGET"); // R10
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned PAGE_SHIFT = DEF_PAGE_SHIFT,
  parameter int unsigned ROW_W      = DEF_ROW_W,
  parameter int unsigned CFG_AW     = DEF_CFG_AW,
  parameter int unsigned PTR_BASE   = 'h80,
  parameter int unsigned CMD_OFS    = 'h90,
  parameter int unsigned STS_OFS    = 'h91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_evt_i,
  input  logic              mbe_evt_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [ROW_W-1:0]  err_row_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  output logic              serr_o
);
  localparam int unsigned PAGE_W  = ADDR_W - PAGE_SHIFT;
  localparam int unsigned STS_W   = 8 * STS_BYTES;
  localparam int unsigned STS_PAD = STS_W - (2 * ROW_W + 2);

  function automatic logic [ADDR_W-1:0] pack_ptr(input logic [PAGE_W-1:0] pg,
                                                 input logic mf, input logic sf);
    return {pg, {(PAGE_SHIFT-2){1'b0}}, mf, sf};
  endfunction

  function automatic logic [STS_W-1:0] pack_sts(input logic [ROW_W-1:0] mr, input logic mf,
                                                input logic [ROW_W-1:0] sr, input logic sf);
    return {{STS_PAD{1'b0}}, mr, mf, sr, sf};
  endfunction

  logic [PAGE_W-1:0]   page;
  logic                psbe, pmbe, capture;
  logic                sef, mef, new_sbe, new_mbe;
  logic [ROW_W-1:0]    srow, mrow;
  logic                clr_psbe, clr_pmbe, clr_sef, clr_mef, cmd_we;
  logic [CMD_BITS-1:0] cmd, cmd_wdata;
  logic                unused_capture;

  assign unused_capture = capture;

  ecc_ptr_reg #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sbe_evt_i(sbe_evt_i), .mbe_evt_i(mbe_evt_i),
    .addr_i(err_addr_i), .clr_sbe_i(clr_psbe), .clr_mbe_i(clr_pmbe),
    .page_o(page), .sbe_flag_o(psbe), .mbe_flag_o(pmbe), .capture_o(capture)
  );

  ecc_sts_reg #(.ROW_W(ROW_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .sbe_evt_i(sbe_evt_i), .mbe_evt_i(mbe_evt_i),
    .row_i(err_row_i), .clr_sef_i(clr_sef), .clr_mef_i(clr_mef),
    .sef_o(sef), .mef_o(mef), .srow_o(srow), .mrow_o(mrow),
    .new_sbe_o(new_sbe), .new_mbe_o(new_mbe)
  );

  ecc_serr_gen #(.CMD_W(CMD_BITS)) u_serr (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .new_sbe_i(new_sbe), .new_mbe_i(new_mbe), .cmd_o(cmd), .serr_o(serr_o)
  );

  ecc_cfg_port #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .CFG_AW(CFG_AW),
    .PTR_BASE(PTR_BASE), .CMD_OFS(CMD_OFS), .STS_OFS(STS_OFS)
  ) u_cfg (
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .ptr_word_i(pack_ptr(page, pmbe, psbe)), .cmd_i(cmd),
    .sts_word_i(pack_sts(mrow, mef, srow, sef)),
    .clr_psbe_o(clr_psbe), .clr_pmbe_o(clr_pmbe), .clr_sef_o(clr_sef),
    .clr_mef_o(clr_mef), .cmd_we_o(cmd_we), .cmd_wdata_o(cmd_wdata),
    .rdata_o(cfg_rdata_o)
  );

  AST_SERR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> ($rose(sef) || $rose(mef))); // R8
  AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_evt_i && mbe_evt_i) |=> (sef && mef)); // R5
endmodule

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe = 1'b0, mbe = 1'b0;
  logic [31:0] eaddr = '0;
  logic [2:0]  erow = '0;
  logic [7:0]  caddr = '0;
  logic        cwr = 1'b0;
  logic [7:0]  cwd = '0;
  logic [7:0]  crd;
  logic        serr;

  always #2.5 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .sbe_evt_i(sbe), .mbe_evt_i(mbe),
    .err_addr_i(eaddr), .err_row_i(erow), .cfg_addr_i(caddr),
    .cfg_wr_i(cwr), .cfg_wdata_i(cwd), .cfg_rdata_o(crd), .serr_o(serr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [19:0] m_page = '0;
  logic        m_ps = 0, m_pm = 0, m_sef = 0, m_mef = 0, m_serr = 0;
  logic [2:0]  m_srow = '0, m_mrow = '0;
  logic [1:0]  m_cmd = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic [7:0] a);
    logic [31:0] pw;
    pw = {m_page, 10'd0, m_pm, m_ps};
    case (a)
      8'h80: return pw[7:0];
      8'h81: return pw[15:8];
      8'h82: return pw[23:16];
      8'h83: return pw[31:24];
      8'h90: return {6'd0, m_cmd};
      8'h91: return {m_mrow, m_mef, m_srow, m_sef};
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd(string tag, logic [7:0] a);
    caddr = a;
    #0.1;
    chk($sformatf("%s rd %h", tag, a), {24'd0, crd}, {24'd0, exp_byte(a)});
  endtask

  task automatic check_regs(string tag);
    foreach (dummy_addrs[k]) rd(tag, dummy_addrs[k]);
  endtask

  logic [7:0] dummy_addrs [10] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h90, 8'h91, 8'h92,
                                   8'h84, 8'h8F, 8'h00};

  task automatic tick(string tag, logic s, logic m, logic [31:0] a, logic [2:0] r,
                      logic w, logic [7:0] wa, logic [7:0] wd);
    logic ns, nm, pc0, pc1, sc0, sc1;
    sbe = s; mbe = m; eaddr = a; erow = r; cwr = w; caddr = wa; cwd = wd;
    @(posedge clk);
    ns  = s & !m_sef;
    nm  = m & !m_mef;
    pc0 = w && wa == 8'h80 && wd[0];
    pc1 = w && wa == 8'h80 && wd[1];
    sc0 = w && wa == 8'h91 && wd[0];
    sc1 = w && wa == 8'h91 && wd[4];
    m_serr = (ns & m_cmd[0]) | (nm & m_cmd[1]);
    if ((s | m) && !m_ps && !m_pm) m_page = a[31:12];
    m_ps = (m_ps & !pc0) | s;
    m_pm = (m_pm & !pc1) | m;
    if (ns) m_srow = r;
    if (nm) m_mrow = r;
    m_sef = (m_sef & !sc0) | s;
    m_mef = (m_mef & !sc1) | m;
    if (w && wa == 8'h90) m_cmd = wd[1:0];
    @(negedge clk);
    sbe = 0; mbe = 0; cwr = 0;
    chk($sformatf("%s serr", tag), {31'd0, serr}, {31'd0, m_serr});
  endtask

  task automatic wr(string tag, logic [7:0] wa, logic [7:0] wd);
    tick(tag, 0, 0, 32'h0, 3'd0, 1, wa, wd);
  endtask

  task automatic ev(string tag, logic s, logic m, logic [31:0] a, logic [2:0] r);
    tick(tag, s, m, a, r, 0, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1C0FFEE5));
    repeat (3) @(negedge clk);
    chk("R1 serr in reset", {31'd0, serr}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check_regs("R1 reset");

    wr("R6 cmd write", 8'h90, 8'hFF);
    rd("R6 cmd", 8'h90);
    ev("R8 first sbe", 1, 0, 32'h1234_5ABC, 3'd5);
    check_regs("R2 R4 R7 after sbe");
    ev("R3 second sbe", 1, 0, 32'hFFFF_F000, 3'd2);
    check_regs("R3 R7 locked");
    ev("R8 first mbe", 0, 1, 32'hABCD_E000, 3'd6);
    check_regs("R3 R7 mbe while locked");
    wr("R4 write upper ptr byte", 8'h81, 8'hFF);
    wr("R4 write zeros", 8'h80, 8'h00);
    check_regs("R4 no effect");
    wr("R4 clear ptr sbe", 8'h80, 8'h01);
    ev("R3 sbe with mbe held", 1, 0, 32'h5555_5000, 3'd1);
    check_regs("R3 still locked");
    wr("R4 clear ptr both", 8'h80, 8'h03);
    wr("R7 clear status", 8'h91, 8'h11);
    check_regs("R4 R7 cleared");
    ev("R5 both strobes", 1, 1, 32'h0F0F_0F0F, 3'd3);
    check_regs("R5 both");
    tick("R9 clear race", 1, 0, 32'h0, 3'd7, 1, 8'h91, 8'h01);
    check_regs("R9 flag stays");
    wr("R10 undefined write", 8'h84, 8'hFF);
    wr("R10 undefined write 0", 8'h00, 8'hFF);
    wr("R10 upper status write", 8'h92, 8'hFF);
    check_regs("R10 ignored");
    wr("R8 cmd off", 8'h90, 8'h00);
    wr("R8 clear sts", 8'h91, 8'h11);
    ev("R8 disabled sbe", 1, 0, 32'h7000_0000, 3'd4);
    wr("R8 mbe only", 8'h90, 8'h02);
    wr("R8 clear sts again", 8'h91, 8'h11);
    ev("R8 sbe not enabled", 1, 0, 32'h0, 3'd1);
    ev("R8 mbe enabled", 0, 1, 32'h0, 3'd2);
    check_regs("R8 classes");

    for (int it = 0; it < 600; it++) begin
      logic s, m, w;
      logic [7:0] wa;
      s = ($urandom % 5) == 0;
      m = ($urandom % 7) == 0;
      w = ($urandom % 3) == 0;
      case ($urandom % 6)
        0: wa = 8'h80;
        1: wa = 8'h91;
        2: wa = 8'h90;
        3: wa = 8'h80 + 8'($urandom % 4);
        4: wa = 8'h91;
        default: wa = 8'($urandom);
      endcase
      tick("RAND R3 R4 R7 R8 R9", s, m, $urandom, 3'($urandom), w, wa, 8'($urandom));
      if (it % 4 == 0) check_regs("RAND R2 R6 R7 R10");
    end
    finish_run();
  end
endmodule